// File: doc/BRIEF.md
# Dual-Edge Pin Input Capture Stage

This block sits between a pin's input buffer and core logic. It conditions a bus of `W` pin inputs before the core sees them. Each lane has a combinational pass-through path. That path drives two outputs, one meant for use as data and one meant for routing into a clock network. Each lane also has a capture path that runs in one of several statically chosen modes.

In single-rate mode, a rising-edge register samples the pin and drives the trailing output. In dual-rate mode, the pin is sampled on both clock edges, and the two streams come out as an aligned pair in the rising-edge domain. An edge-swap control selects which edge begins each pair.

A shared enable qualifies every capture register. A synchronous local reset overrides the enable and loads a parameter-selected value, either all ones or all zeros.

Top module: `ddr_in_cap`

## Requirements
- R1: `byp_data` equals `pin_in` combinationally at all times, whatever the mode, enable or reset.
- R2: `byp_clk` equals `pin_in` combinationally at all times, whatever the mode, enable or reset.
- R3: With `cap_mode` = 2'd1 (single rate), `cen` high and `srst` low, each rising edge loads `q_trail` with `pin_in` as sampled at that edge, and loads `q_lead` with the reset value.
- R4: With `cap_mode` = 2'd2 (dual rate), `edge_swap` low, and the enable high at both edges concerned, after rising edge k `q_lead` holds the pin sampled at rising edge k-1. At the same point `q_trail` holds the pin sampled at the falling edge between k-1 and k. Both outputs change only at rising edges.
- R5: With `cap_mode` = 2'd2 and `edge_swap` high, after rising edge k `q_lead` holds the pin sampled at the falling edge between k-1 and k, and `q_trail` holds the pin sampled at rising edge k.
- R6: With `cap_mode` = 2'd0 (pass-through only) or the unused code 2'd3, each enabled rising edge loads both `q_lead` and `q_trail` with the reset value.
- R7: While `cen` is low, every capture register holds its value at both clock edges. This includes the falling-edge sample, which reappears on the outputs once the enable returns in dual-rate mode.
- R8: `srst` high at a rising edge loads `q_lead` and `q_trail` with the reset value (all ones when `RST_ONE` = 1, all zeros otherwise), even when `cen` is low. `srst` high at a falling edge also resets the falling-edge sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both edges are used for capture |
| srst | input | 1 | Synchronous local set/reset, active high |
| cen | input | 1 | Capture enable for all registers |
| cap_mode | input | 2 | Static mode: 0 pass-through, 1 single rate, 2 dual rate, 3 treated as 0 |
| edge_swap | input | 1 | Dual-rate polarity: high makes the falling edge lead each pair |
| pin_in | input | W | Pin input from the buffer |
| byp_data | output | W | Unregistered pin data |
| byp_clk | output | W | Unregistered pin copy for use as a clock |
| q_lead | output | W | Leading sample of a dual-rate pair |
| q_trail | output | W | Single-rate capture, or trailing sample of a dual-rate pair |

## Verification
The hardest case to reach from the ports is the falling-edge sample being held through a stall. It only becomes visible one rising edge after the enable returns, and only in dual-rate mode. The stimulus therefore drives a different pin value in each half cycle. It drops the enable for several cycles while the pin keeps toggling, then raises it again, so `q_trail` must show the value captured before the stall and not a later one. The swapped polarity is exercised with the same half-cycle stimulus, because there the trailing output takes the pin at the current edge while the leading output takes the earlier falling sample.

// File: rtl/ddr_in_pkg.sv
`timescale 1ns/1ps
package ddr_in_pkg;
    typedef enum logic [1:0] {
        CAP_PASS  = 2'd0,
        CAP_SDR   = 2'd1,
        CAP_DDR   = 2'd2,
        CAP_SPARE = 2'd3
    } cap_mode_e;
endpackage

// File: rtl/ddr_in_passthru.sv
`timescale 1ns/1ps
module ddr_in_passthru #(
    parameter int W = 4
) (
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] byp_data,
    output logic [W-1:0] byp_clk
);
    for (genvar i = 0; i < W; i++) begin : g_lane
        assign byp_data[i] = pin_in[i];
        assign byp_clk[i]  = pin_in[i];
    end
endmodule

// File: rtl/ddr_in_fall_stage.sv
`timescale 1ns/1ps
module ddr_in_fall_stage #(
    parameter int   W       = 4,
    parameter logic RST_ONE = 1'b0
) (
    input  logic         clk,
    input  logic         srst,
    input  logic         cen,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] fall_smp
);
    localparam logic [W-1:0] RV = {W{RST_ONE}};

    logic [W-1:0] fall_d, fall_q;

    always_comb begin
        fall_d = fall_q;
        if (srst)
            fall_d = RV;
        else if (cen)
            fall_d = pin_in;
    end

    always_ff @(negedge clk) begin
        fall_q <= fall_d;
    end

    assign fall_smp = fall_q;
endmodule

// File: rtl/ddr_in_align.sv
`timescale 1ns/1ps
module ddr_in_align
    import ddr_in_pkg::*;
#(
    parameter int   W       = 4,
    parameter logic RST_ONE = 1'b0
) (
    input  logic         clk,
    input  logic         srst,
    input  logic         cen,
    input  logic [1:0]   cap_mode,
    input  logic         edge_swap,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] fall_smp,
    output logic [W-1:0] q_lead,
    output logic [W-1:0] q_trail
);
    localparam logic [W-1:0] RV = {W{RST_ONE}};

    typedef struct packed {
        logic [W-1:0] rise;
        logic [W-1:0] lead;
        logic [W-1:0] trail;
    } rise_state_t;

    rise_state_t st_d, st_q;
    cap_mode_e   mode;

    assign mode = cap_mode_e'(cap_mode);

    always_comb begin
        st_d = st_q;
        if (srst) begin
            st_d.rise  = RV;
            st_d.lead  = RV;
            st_d.trail = RV;
        end else if (cen) begin
            st_d.rise = pin_in;
            unique case (mode)
                CAP_SDR: begin
                    st_d.lead  = RV;
                    st_d.trail = pin_in;
                end
                CAP_DDR: begin
                    if (edge_swap) begin
                        st_d.lead  = fall_smp;
                        st_d.trail = pin_in;
                    end else begin
                        st_d.lead  = st_q.rise;
                        st_d.trail = fall_smp;
                    end
                end
                default: begin
                    st_d.lead  = RV;
                    st_d.trail = RV;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q_lead  = st_q.lead;
    assign q_trail = st_q.trail;
endmodule

// File: rtl/ddr_in_cap.sv
`timescale 1ns/1ps
module ddr_in_cap #(
    parameter int   W       = 4,
    parameter logic RST_ONE = 1'b0
) (
    input  logic         clk,
    input  logic         srst,
    input  logic         cen,
    input  logic [1:0]   cap_mode,
    input  logic         edge_swap,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] byp_data,
    output logic [W-1:0] byp_clk,
    output logic [W-1:0] q_lead,
    output logic [W-1:0] q_trail
);
    logic [W-1:0] fall_smp;

    ddr_in_passthru #(.W(W)) u_pass (
        .pin_in   (pin_in),
        .byp_data (byp_data),
        .byp_clk  (byp_clk)
    );

    ddr_in_fall_stage #(.W(W), .RST_ONE(RST_ONE)) u_fall (
        .clk      (clk),
        .srst     (srst),
        .cen      (cen),
        .pin_in   (pin_in),
        .fall_smp (fall_smp)
    );

    ddr_in_align #(.W(W), .RST_ONE(RST_ONE)) u_align (
        .clk       (clk),
        .srst      (srst),
        .cen       (cen),
        .cap_mode  (cap_mode),
        .edge_swap (edge_swap),
        .pin_in    (pin_in),
        .fall_smp  (fall_smp),
        .q_lead    (q_lead),
        .q_trail   (q_trail)
    );
endmodule

// File: rtl/ddr_in_cap_chk.sv
`timescale 1ns/1ps
module ddr_in_cap_chk #(
    parameter int   W       = 4,
    parameter logic RST_ONE = 1'b0
) (
    input logic         clk,
    input logic         srst,
    input logic         cen,
    input logic [1:0]   cap_mode,
    input logic         edge_swap,
    input logic [W-1:0] pin_in,
    input logic [W-1:0] byp_data,
    input logic [W-1:0] byp_clk,
    input logic [W-1:0] q_lead,
    input logic [W-1:0] q_trail
);
    localparam logic [W-1:0] RV = {W{RST_ONE}};

    AST_BYP_DATA: assert property (@(posedge clk) byp_data == pin_in); // R1
    AST_BYP_CLK: assert property (@(posedge clk) byp_clk == pin_in); // R2
    AST_RST_LOAD: assert property (@(posedge clk) srst |=> (q_lead == RV && q_trail == RV)); // R8
    AST_CE_HOLD: assert property (@(posedge clk) disable iff (srst) !cen |=> ($stable(q_lead) && $stable(q_trail))); // R7
    AST_SDR_TRAIL: assert property (@(posedge clk) disable iff (srst) (cen && cap_mode == 2'd1) |=> q_trail == $past(pin_in)); // R3
    AST_SDR_LEAD: assert property (@(posedge clk) disable iff (srst) (cen && cap_mode == 2'd1) |=> q_lead == RV); // R3
    AST_DDR_LEAD: assert property (@(posedge clk) disable iff (srst) (cen && cap_mode == 2'd2 && !edge_swap && $past(cen) && !$past(srst)) |=> q_lead == $past(pin_in, 2)); // R4
    AST_SWAP_TRAIL: assert property (@(posedge clk) disable iff (srst) (cen && cap_mode == 2'd2 && edge_swap) |=> q_trail == $past(pin_in)); // R5
    AST_IDLE_MODE: assert property (@(posedge clk) disable iff (srst) (cen && (cap_mode == 2'd0 || cap_mode == 2'd3)) |=> (q_lead == RV && q_trail == RV)); // R6
endmodule

bind ddr_in_cap ddr_in_cap_chk #(.W(W), .RST_ONE(RST_ONE)) u_chk (
    .clk       (clk),
    .srst      (srst),
    .cen       (cen),
    .cap_mode  (cap_mode),
    .edge_swap (edge_swap),
    .pin_in    (pin_in),
    .byp_data  (byp_data),
    .byp_clk   (byp_clk),
    .q_lead    (q_lead),
    .q_trail   (q_trail)
);

// File: tb/tb_ddr_in_cap.sv
`timescale 1ns/1ps
module tb_ddr_in_cap;
    localparam int   W       = 4;
    localparam logic RST_ONE = 1'b1;
    localparam logic [W-1:0] RV = {W{RST_ONE}};

    logic         clk = 1'b0;
    logic         srst = 1'b1;
    logic         cen = 1'b1;
    logic [1:0]   cap_mode = 2'd0;
    logic         edge_swap = 1'b0;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] byp_data, byp_clk, q_lead, q_trail;

    always #2 clk = ~clk;

    ddr_in_cap #(.W(W), .RST_ONE(RST_ONE)) dut (
        .clk(clk), .srst(srst), .cen(cen), .cap_mode(cap_mode),
        .edge_swap(edge_swap), .pin_in(pin_in), .byp_data(byp_data),
        .byp_clk(byp_clk), .q_lead(q_lead), .q_trail(q_trail)
    );

    typedef struct {
        logic [W-1:0] e_lead;
        logic [W-1:0] e_trail;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference state taken from the requirements
    logic [W-1:0] m_rise = RV, m_fall = RV, m_lead = RV, m_trail = RV;
    bit prev_ce_low = 1'b0;

    task automatic check_bypass();
        checks++;
        if (byp_data !== pin_in) begin
            failures++;
            $display("FAIL R1 byp_data actual=%h expected=%h", byp_data, pin_in);
        end
        checks++;
        if (byp_clk !== pin_in) begin
            failures++;
            $display("FAIL R2 byp_clk actual=%h expected=%h", byp_clk, pin_in);
        end
    endtask

    task automatic run_cycle(input logic [W-1:0] r, input logic [W-1:0] f,
                             input logic ce_v, input logic rst_v,
                             input logic [1:0] mode_v, input logic sw_v);
        exp_t e;
        @(negedge clk);
        #1;
        srst = rst_v; cen = ce_v; cap_mode = mode_v; edge_swap = sw_v; pin_in = r;
        #0.5;
        check_bypass();
        // rising-edge outcome
        if (rst_v) begin
            m_lead = RV; m_trail = RV; m_rise = RV;
            e.tag = "R8";
        end else if (ce_v) begin
            case (mode_v)
                2'd1: begin m_lead = RV; m_trail = r; e.tag = "R3"; end
                2'd2: begin
                    if (sw_v) begin m_lead = m_fall; m_trail = r; e.tag = "R5"; end
                    else begin m_lead = m_rise; m_trail = m_fall; e.tag = "R4"; end
                end
                default: begin m_lead = RV; m_trail = RV; e.tag = "R6"; end
            endcase
            m_rise = r;
            if (prev_ce_low) e.tag = {e.tag, " R7"};
        end else begin
            e.tag = "R7";
        end
        prev_ce_low = !rst_v && !ce_v;
        e.e_lead = m_lead;
        e.e_trail = m_trail;
        exp_q.push_back(e);
        @(posedge clk);
        #1;
        pin_in = f;
        #0.5;
        check_bypass();
        // falling-edge outcome
        if (rst_v) m_fall = RV;
        else if (ce_v) m_fall = f;
    endtask

    // monitor: outputs change only at rising edges, so compare at falling edges
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (q_lead !== e.e_lead || q_trail !== e.e_trail) begin
                    failures++;
                    $display("FAIL %s lead/trail actual=%h/%h expected=%h/%h",
                             e.tag, q_lead, q_trail, e.e_lead, e.e_trail);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R8 reset state, with enable high and then low
        run_cycle(4'h3, 4'hc, 1'b1, 1'b1, 2'd2, 1'b0);
        run_cycle(4'h5, 4'ha, 1'b0, 1'b1, 2'd2, 1'b0);
        // R3 single rate
        for (int i = 0; i < 6; i++)
            run_cycle(4'($urandom), 4'($urandom), 1'b1, 1'b0, 2'd1, 1'b0);
        // R4 dual rate, fixed and random patterns
        run_cycle(4'h0, 4'hf, 1'b1, 1'b0, 2'd2, 1'b0);
        run_cycle(4'ha, 4'h5, 1'b1, 1'b0, 2'd2, 1'b0);
        for (int i = 0; i < 8; i++)
            run_cycle(4'($urandom), 4'($urandom), 1'b1, 1'b0, 2'd2, 1'b0);
        // R7 stall while pin toggles, then resume in dual rate
        run_cycle(4'h1, 4'h2, 1'b1, 1'b0, 2'd2, 1'b0);
        run_cycle(4'h9, 4'h6, 1'b0, 1'b0, 2'd2, 1'b0);
        run_cycle(4'he, 4'h7, 1'b0, 1'b0, 2'd2, 1'b0);
        run_cycle(4'h4, 4'hb, 1'b1, 1'b0, 2'd2, 1'b0);
        run_cycle(4'hd, 4'h8, 1'b1, 1'b0, 2'd2, 1'b0);
        // R5 swapped polarity
        for (int i = 0; i < 8; i++)
            run_cycle(4'($urandom), 4'($urandom), 1'b1, 1'b0, 2'd2, 1'b1);
        run_cycle(4'h3, 4'h6, 1'b0, 1'b0, 2'd2, 1'b1);
        run_cycle(4'hc, 4'h1, 1'b1, 1'b0, 2'd2, 1'b1);
        // R6 pass-through and spare code
        for (int i = 0; i < 3; i++)
            run_cycle(4'($urandom), 4'($urandom), 1'b1, 1'b0, 2'd0, 1'b0);
        run_cycle(4'h6, 4'h9, 1'b1, 1'b0, 2'd1, 1'b0);
        for (int i = 0; i < 3; i++)
            run_cycle(4'($urandom), 4'($urandom), 1'b1, 1'b0, 2'd3, 1'b0);
        // R8 reset mid-run wins over a low enable, falling sample reset too
        run_cycle(4'h0, 4'h0, 1'b1, 1'b0, 2'd2, 1'b0);
        run_cycle(4'h0, 4'h0, 1'b1, 1'b0, 2'd2, 1'b0);
        run_cycle(4'h2, 4'h4, 1'b0, 1'b1, 2'd2, 1'b0);
        run_cycle(4'h8, 4'h2, 1'b1, 1'b0, 2'd2, 1'b0);
        run_cycle(4'h1, 4'h7, 1'b1, 1'b0, 2'd2, 1'b0);
        // R3 single rate with enable toggling
        for (int i = 0; i < 8; i++)
            run_cycle(4'($urandom), 4'($urandom), 1'(i % 3 != 1), 1'b0, 2'd1, 1'b0);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule